// File: doc/BRIEF.md
# Bi-mode conditional branch direction predictor

This block predicts whether a conditional branch is taken. A selector table of 2-bit saturating counters, indexed by the low bits of the branch address, chooses which of two direction tables gives the answer. One direction table starts out leaning toward taken, the other toward not taken. Both are indexed by the address index XORed with a global history of resolved outcomes. Branches that are usually taken collect in one table and branches that are usually not taken collect in the other, so two branches that share an entry tend to push it the same way.

The predict side is purely combinational. A fetch stage presents a PC and gets back the direction, the selector bit and the direction-table index. The pipeline carries these with the branch. When the branch resolves, they are returned on the resolve port together with the PC and the real outcome. Only the direction table that was used is trained. The selector counter trains toward the outcome, except when the selector pointed the wrong way and the chosen direction counter was still right; in that case the selector is left as it is.

Top module: `bimode_dir_pred`

## Requirements
- R1: After reset every selector counter and every taken-table counter holds 2 (binary 10), every not-taken-table counter holds 1 (binary 01), and the history is zero. Every PC therefore predicts taken with `pred_sel` = 1 and `pred_dir_idx` equal to the PC index.
- R2: The selector index is `pc[ALIGN +: IDX_W]`. `pred_sel` is bit 1 (the high bit) of the selector counter at that index.
- R3: `pred_dir_idx` is the selector index XOR the history, with the history zero-extended to `IDX_W` bits.
- R4: `pred_taken` is bit 1 of the counter at `pred_dir_idx`. That counter is read from the taken table when `pred_sel` is 1 and from the not-taken table when it is 0.
- R5: When `res_valid` is high, the counter at `res_dir_idx` in the table named by `res_sel` (1 = taken table, 0 = not-taken table) steps one count toward `res_taken`. The other direction table is not changed. Without `res_valid`, no table changes.
- R6: When `res_valid` is high, the selector counter at the index of `res_pc` steps toward `res_taken`. The one exception: it holds when `res_sel` differs from `res_taken` and `res_pred` equals `res_taken`.
- R7: Each valid resolve shifts the history left by one and puts `res_taken` into bit 0 (1 = taken). With no resolve, the history holds.
- R8: A predict and a resolve in the same cycle are both served. The predict sees the table and history contents from before that cycle's update, and the update becomes visible from the next cycle.
- R9: Counters saturate. A counter at 3 stays at 3 on a taken step, and a counter at 0 stays at 0 on a not-taken step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Address of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_sel | output | 1 | Selector decision, 1 = taken table used |
| pred_dir_idx | output | IDX_W | Direction-table index used for this prediction |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_sel | input | 1 | `pred_sel` captured at predict time |
| res_pred | input | 1 | `pred_taken` captured at predict time |
| res_dir_idx | input | IDX_W | `pred_dir_idx` captured at predict time |

## Verification
The bound checker watches, on every cycle, that a resolve never changes the unselected direction table, that no table moves without a resolve, that the selector table stays frozen in the hold case, and that the history shifts or holds as required. The counter values themselves, the index hash, the reset contents, saturation and the read-before-write ordering of a same-cycle predict and resolve can only be seen through the bench's scenarios. The bench sweeps every PC index and every combination of captured selector, captured prediction and outcome against an arithmetic model of the three tables.

// File: rtl/bimode_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the bi-mode predictor.
// Assumes 2-bit saturating counters everywhere.
package bimode_pkg;
    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WNT = 2'b01;
    localparam ctr2_t CTR_WT  = 2'b10;

    // One saturating step of a 2-bit counter toward the given direction.
    function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
        ctr2_t n;
        if (up) n = (c == 2'b11) ? c : c + 2'd1;
        else    n = (c == 2'b00) ? c : c - 2'd1;
        return n;
    endfunction
endpackage

// File: rtl/bm_ghist.sv
`timescale 1ns/1ps
// Global outcome history register.
// Shifts left on each enabled cycle and takes the new outcome into bit 0.
// Assumes a synchronous active-low reset that clears it.
module bm_ghist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist
);
    // Shift register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        hist <= '0;
        else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
    end
endmodule

// File: rtl/bm_ctr_table.sv
`timescale 1ns/1ps
// Table of 2-bit saturating counters with one combinational read port
// and one registered write port that steps a single entry.
// Assumes the read returns the content from before a same-cycle write.
module bm_ctr_table
    import bimode_pkg::*;
#(
    parameter int    IDX_W   = 10,
    parameter ctr2_t RST_VAL = CTR_WT
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IDX_W-1:0]         rd_idx,
    output ctr2_t                    rd_ctr,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic                     wr_up,
    output logic [2*(1<<IDX_W)-1:0]  state_flat
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    // Reset every entry, or step the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= RST_VAL;
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
        end
    end

    // Combinational read of the pre-update content.
    assign rd_ctr = mem[rd_idx];

    // Flattened view of the array for the checker.
    always_comb begin
        for (int e = 0; e < DEPTH; e++) state_flat[2*e +: 2] = mem[e];
    end
endmodule

// File: rtl/bimode_dir_pred.sv
`timescale 1ns/1ps
// Bi-mode direction predictor top level.
// A selector table picks a taken-leaning or a not-taken-leaning direction
// table. The direction tables are indexed by PC index XOR global history.
// Assumes HIST_W <= IDX_W and that the resolve fields are the ones produced
// at predict time for the same branch.
module bimode_dir_pred
    import bimode_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int ALIGN  = 2,
    parameter int IDX_W  = 10,
    parameter int HIST_W = IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic             pred_sel,
    output logic [IDX_W-1:0] pred_dir_idx,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic             res_sel,
    input  logic             res_pred,
    input  logic [IDX_W-1:0] res_dir_idx
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int FLAT_W = 2 * DEPTH;

    logic [IDX_W-1:0]  pred_ci;
    logic [IDX_W-1:0]  res_ci;
    logic [IDX_W-1:0]  hist_ext;
    logic [HIST_W-1:0] ghist;
    logic              choice_hold;
    ctr2_t             choice_rd;
    ctr2_t             dir_rd [2];
    logic [FLAT_W-1:0] choice_flat;
    logic [FLAT_W-1:0] dir_flat [2];
    logic [FLAT_W-1:0] tk_flat;
    logic [FLAT_W-1:0] nt_flat;
    logic              unused_pc_bits;

    // Address index extraction for both ports.
    always_comb begin
        pred_ci = pred_pc[ALIGN +: IDX_W];
        res_ci  = res_pc[ALIGN +: IDX_W];
    end

    // Address bits outside the index have no role.
    assign unused_pc_bits = ^{pred_pc, res_pc};

    // Zero-extend the history to the index width.
    always_comb begin
        hist_ext = '0;
        hist_ext[HIST_W-1:0] = ghist;
    end

    // Selector training is frozen when it was wrong but the chosen table was right.
    assign choice_hold = (res_sel != res_taken) && (res_pred == res_taken);

    bm_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WT)) u_choice (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (pred_ci),
        .rd_ctr     (choice_rd),
        .wr_en      (res_valid && !choice_hold),
        .wr_idx     (res_ci),
        .wr_up      (res_taken),
        .state_flat (choice_flat)
    );

    // Direction tables: index 1 leans taken, index 0 leans not taken.
    for (genvar g = 0; g < 2; g++) begin : g_dir
        localparam ctr2_t RV = (g == 1) ? CTR_WT : CTR_WNT;
        bm_ctr_table #(.IDX_W(IDX_W), .RST_VAL(RV)) u_tab (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_idx     (pred_dir_idx),
            .rd_ctr     (dir_rd[g]),
            .wr_en      (res_valid && (res_sel == (g == 1))),
            .wr_idx     (res_dir_idx),
            .wr_up      (res_taken),
            .state_flat (dir_flat[g])
        );
    end

    assign tk_flat = dir_flat[1];
    assign nt_flat = dir_flat[0];

    bm_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist     (ghist)
    );

    // Prediction path: hash, select, read.
    always_comb begin
        pred_dir_idx = pred_ci ^ hist_ext;
        pred_sel     = choice_rd[1];
        pred_taken   = pred_sel ? dir_rd[1][1] : dir_rd[0][1];
    end
endmodule

// File: rtl/bimode_checks.sv
`timescale 1ns/1ps
// Cycle-by-cycle property checker for the bi-mode predictor, bound to the top.
// Assumes HIST_W >= 2.
module bimode_checks #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     res_valid,
    input logic                     res_taken,
    input logic                     res_sel,
    input logic                     res_pred,
    input logic [HIST_W-1:0]        hist,
    input logic [2*(1<<IDX_W)-1:0]  ch_flat,
    input logic [2*(1<<IDX_W)-1:0]  tk_flat,
    input logic [2*(1<<IDX_W)-1:0]  nt_flat
);
    // A resolve into the taken table leaves the not-taken table alone.
    p_unsel_nt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sel) |=> (nt_flat == $past(nt_flat)));

    // A resolve into the not-taken table leaves the taken table alone.
    p_unsel_tk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_sel) |=> (tk_flat == $past(tk_flat)));

    // No table moves in a cycle without a resolve.
    p_idle_tables_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> ((ch_flat == $past(ch_flat)) && (tk_flat == $past(tk_flat))
                        && (nt_flat == $past(nt_flat))));

    // The selector table is frozen in the hold case.
    p_choice_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_sel != res_taken) && (res_pred == res_taken))
        |=> (ch_flat == $past(ch_flat)));

    // The history takes in the outcome at bit 0.
    p_hist_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ((hist[0] == $past(res_taken))
                       && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]))));

    // The history holds without a resolve.
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hist));
endmodule

bind bimode_dir_pred bimode_checks #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .res_sel   (res_sel),
    .res_pred  (res_pred),
    .hist      (ghist),
    .ch_flat   (choice_flat),
    .tk_flat   (tk_flat),
    .nt_flat   (nt_flat)
);

// File: tb/sim_bimode_dir_pred.sv
`timescale 1ns/1ps
// Bench: small configuration (8 entries, 3-bit history) checked against an
// arithmetic model of the three counter tables and the history.
module sim_bimode_dir_pred;
    localparam int PC_W = 8, ALIGN = 2, IDX_W = 3, HIST_W = 3;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [PC_W-1:0]  pred_pc = '0;
    logic             pred_taken, pred_sel;
    logic [IDX_W-1:0] pred_dir_idx;
    logic             res_valid = 1'b0;
    logic [PC_W-1:0]  res_pc = '0;
    logic             res_taken = 1'b0, res_sel = 1'b0, res_pred = 1'b0;
    logic [IDX_W-1:0] res_dir_idx = '0;

    int nchk = 0, nfail = 0;
    int m_ch [DEPTH];
    int m_tk [DEPTH];
    int m_nt [DEPTH];
    int m_hist = 0;
    logic [15:0] lf = 16'hACE1;
    logic e_t, e_s;
    logic [IDX_W-1:0] e_di;

    bimode_dir_pred #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W), .HIST_W(HIST_W)) u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_sel(pred_sel), .pred_dir_idx(pred_dir_idx), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_sel(res_sel),
        .res_pred(res_pred), .res_dir_idx(res_dir_idx)
    );

    always #2.5 clk = ~clk;

    function automatic int step(input int c, input logic up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic lfsr_next();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // One cycle: drive both ports, check the prediction against the
    // pre-update model (R8), then apply the resolve to the model.
    task automatic cyc(input logic [PC_W-1:0] pc, input logic rv,
                       input logic [PC_W-1:0] rpc, input logic rt,
                       input logic rs, input logic rp, input logic [IDX_W-1:0] rdi,
                       input string tag);
        int ci, di, rci;
        @(negedge clk);
        pred_pc = pc; res_valid = rv; res_pc = rpc; res_taken = rt;
        res_sel = rs; res_pred = rp; res_dir_idx = rdi;
        #1;
        ci   = int'(pc[ALIGN +: IDX_W]);
        di   = ci ^ m_hist;
        e_di = IDX_W'(di);
        e_s  = (m_ch[ci] >= 2);
        e_t  = e_s ? (m_tk[di] >= 2) : (m_nt[di] >= 2);
        chk(pred_dir_idx == e_di, {tag, " R3 dir_idx"}, int'(pred_dir_idx), di);
        chk(pred_sel == e_s, {tag, " R2 sel"}, int'(pred_sel), int'(e_s));
        chk(pred_taken == e_t, {tag, " R4 taken"}, int'(pred_taken), int'(e_t));
        if (rv) begin
            rci = int'(rpc[ALIGN +: IDX_W]);
            if (rs) m_tk[rdi] = step(m_tk[rdi], rt);
            else    m_nt[rdi] = step(m_nt[rdi], rt);
            if (!((rs != rt) && (rp == rt))) m_ch[rci] = step(m_ch[rci], rt);
            m_hist = ((m_hist << 1) | int'(rt)) & (DEPTH - 1);
        end
    endtask

    function automatic logic [PC_W-1:0] pc_of(input int idx);
        return PC_W'(idx << ALIGN);
    endfunction

    initial begin : wd
        #(200000 * 5);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : main
        logic pv, pt, ps, po;
        logic [PC_W-1:0] ppc;
        logic [IDX_W-1:0] pdi;
        for (int e = 0; e < DEPTH; e++) begin m_ch[e] = 2; m_tk[e] = 2; m_nt[e] = 1; end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset contents seen through every index, with upper PC bits varied.
        for (int i = 0; i < DEPTH; i++) begin
            cyc(pc_of(i) | 8'h81, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R1 reset");
            chk(pred_taken && pred_sel && (pred_dir_idx == IDX_W'(i)), "R1 reset state",
                int'({pred_taken, pred_sel}), 3);
        end

        // R6: hold case twice, selector must still choose the taken table.
        cyc(pc_of(5), 1'b1, pc_of(5), 1'b0, 1'b1, 1'b0, 3'd5, "R6 hold a");
        cyc(pc_of(5), 1'b1, pc_of(5), 1'b0, 1'b1, 1'b0, 3'd5, "R6 hold b");
        cyc(pc_of(5), 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R6 hold c");
        chk(pred_sel == 1'b1, "R6 selector held", int'(pred_sel), 1);
        // R6: same disagreement with a wrong direction: selector moves to not taken.
        cyc(pc_of(5), 1'b1, pc_of(5), 1'b0, 1'b1, 1'b1, 3'd5, "R6 move");
        cyc(pc_of(5), 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R6 move chk");
        chk(pred_sel == 1'b0, "R6 selector moved", int'(pred_sel), 0);

        // R9: drive one taken-table entry up past saturation, then down.
        for (int n = 0; n < 5; n++)
            cyc(pc_of(2), 1'b1, pc_of(2), 1'b1, 1'b1, 1'b1, 3'd6, "R9 up");
        for (int n = 0; n < 5; n++)
            cyc(pc_of(2), 1'b1, pc_of(2), 1'b0, 1'b1, 1'b0, 3'd6, "R9 down");

        // R8/R7: same branch predicted and resolved in the same cycle, loop pattern.
        for (int n = 0; n < 48; n++) begin
            cyc(pc_of(3), 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R8 probe");
            cyc(pc_of(3), 1'b1, pc_of(3), (n % 4) != 3, e_s, e_t, e_di, "R8 same-cycle");
        end

        // R5/R6: every index with every selector, captured prediction and outcome.
        for (int i = 0; i < DEPTH; i++)
            for (int c = 0; c < 8; c++)
                cyc(pc_of((i + c) % DEPTH), 1'b1, pc_of(i), c[0], c[1], c[2],
                    IDX_W'(i ^ c), "R5 sweep");

        // R4/R7: pipelined stream, each branch resolved one cycle after prediction.
        pv = 1'b0; ppc = '0; pt = 1'b0; ps = 1'b0; po = 1'b0; pdi = '0;
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] npc;
            lfsr_next();
            npc = PC_W'(lf[9:0]);
            po  = ppc[ALIGN] ^ (lf[15] & lf[14] & lf[11]);
            cyc(npc, pv, ppc, po, ps, pt, pdi, "R7 stream");
            pv = 1'b1; ppc = npc; pt = e_t; ps = e_s; pdi = e_di;
        end

        // R1: reset again in mid-run restores the initial contents.
        @(negedge clk); rst_n = 1'b0; res_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int e = 0; e < DEPTH; e++) begin m_ch[e] = 2; m_tk[e] = 2; m_nt[e] = 1; end
        m_hist = 0;
        for (int i = 0; i < DEPTH; i++)
            cyc(pc_of(i), 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, "R1 re-reset");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule